// File: doc/BRIEF.md
# Hardware Debug Halt Entry Controller

This block decides when a processor core halts for a hardware debug session and when it returns to normal execution. A halt can be requested in two independent ways: an external debugger pulls an active-low run/stop pin low, or the test-access-port logic holds a decoded instruction that selects debug mode. A halt begins only on an instruction boundary reported by the core. The block then raises a probe-ready acknowledge. It holds instruction fetch and masks every interrupt for as long as the acknowledge is high.

The session ends only when every request that was raised has been withdrawn. The pin request is withdrawn by a low-to-high transition of the pin. The port request is withdrawn by clearing the port's instruction register or by a port reset. A reset request from the system that arrives during a session is flagged as a protocol violation.

Top module: `debug_halt_ctrl`

## Requirements
- R1: While `rstN` is low, `probeAck`, `stallFetch` and `intMask` are 0 and both stored halt requests are cleared. After reset is released with no request present, the acknowledge stays 0.
- R2: `runStopN` passes through a two-flop synchroniser. When it falls, `probeAck` is 1 after the fourth rising clock edge following the change, provided `instrBoundary` is 1 at that edge.
- R3: Holding `tapDbgSel` at 1 raises `probeAck` at the second rising edge after it is driven, provided `instrBoundary` is 1 at that edge. No transition on `runStopN` is needed.
- R4: `probeAck` never goes from 0 to 1 at an edge where `instrBoundary` is 0. A pending request is kept until a boundary arrives.
- R5: With no port request active, a rising transition of `runStopN` makes `probeAck` 0 after the fourth rising edge following the change, one clock after the pin request is dropped.
- R6: With no pin request active, a one-cycle pulse of `tapIrClear` or `tapReset` makes `probeAck` 0 after the second rising edge following the pulse.
- R7: The acknowledge falls only after the later of the two releases. It stays 1 while either request is still active, whichever is withdrawn first.
- R8: `stallFetch` and `intMask` equal `probeAck` in every cycle.
- R9: `resetViolation` is 1 exactly when `resetReq` is 1 while `probeAck` is 1.
- R10: Once `probeAck` is 1, it stays 1 while any request is active, whatever the value of `instrBoundary`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| runStopN | input | 1 | Asynchronous active-low halt request pin from external debug logic |
| tapDbgSel | input | 1 | Level: the port instruction register holds the debug-select instruction |
| tapIrClear | input | 1 | Pulse: the port instruction register was cleared |
| tapReset | input | 1 | Pulse: the test-access port was reset |
| instrBoundary | input | 1 | Strobe from the core marking an instruction boundary |
| resetReq | input | 1 | System reset request, used only for violation flagging |
| probeAck | output | 1 | Probe-ready acknowledge, high during a debug session |
| stallFetch | output | 1 | Holds instruction fetch during a session |
| intMask | output | 1 | Masks SMI and all other interrupts during a session |
| resetViolation | output | 1 | Reset requested while the session is active |

## Verification
The bench drives each entry path alone, then both paths together with the pin released first, and then with the port released first. These runs separate an OR of the requests from a design that follows only the most recent event. Runs with the boundary strobe held low for several cycles show whether entry is truly gated, and runs with the strobe dropped during a session show whether the acknowledge holds. The pipeline depth on both edges of the pin is measured cycle by cycle, and a system reset is applied in the middle of a session to show that the stored requests are cleared.

// File: rtl/dhc_pkg.sv
package dhc_pkg;

  // Strobes from the control to the datapath: raise or drop each stored halt cause
  typedef struct packed {
    logic setPin;
    logic clrPin;
    logic setTap;
    logic clrTap;
  } causeStrb_t;

  // Session state kept in the datapath
  typedef enum logic [1:0] {
    DBG_OFF  = 2'b00,
    DBG_PEND = 2'b01,
    DBG_ON   = 2'b10
  } dbgState_t;

endpackage

// File: rtl/dhc_control.sv
module dhc_control
  import dhc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runStopN,
  input  logic       tapDbgSel,
  input  logic       tapIrClear,
  input  logic       tapReset,
  output causeStrb_t strb
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic pinPrev;
  logic pinLow;
  logic pinRise;

  // Synchroniser chain; the pin idles high, so reset loads ones
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[0] <= 1'b1;
        else       syncQ[0] <= runStopN;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[i] <= 1'b1;
        else       syncQ[i] <= syncQ[i-1];
      end
    end
  end

  // History flop for edge detection on the synchronised pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= 1'b1;
    else       pinPrev <= syncQ[LAST];
  end

  assign pinLow  = ~syncQ[LAST];
  assign pinRise = syncQ[LAST] & ~pinPrev;

  always_comb begin
    strb.setPin = pinLow;
    strb.clrPin = pinRise;
    strb.setTap = tapDbgSel;
    strb.clrTap = tapIrClear | tapReset;
  end

endmodule

// File: rtl/dhc_datapath.sv
module dhc_datapath
  import dhc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  causeStrb_t strb,
  input  logic       instrBoundary,
  input  logic       resetReq,
  output logic       probeAck,
  output logic       stallFetch,
  output logic       intMask,
  output logic       resetViolation
);

  logic pinCause;
  logic tapCause;
  logic anyCause;
  dbgState_t state;
  dbgState_t stateNxt;

  // Stored pin cause: the rising edge drops it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pinCause <= 1'b0;
    else if (strb.clrPin) pinCause <= 1'b0;
    else if (strb.setPin) pinCause <= 1'b1;
  end

  // Stored port cause: a clear or port reset wins over the select
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tapCause <= 1'b0;
    else if (strb.clrTap) tapCause <= 1'b0;
    else if (strb.setTap) tapCause <= 1'b1;
  end

  assign anyCause = pinCause | tapCause;

  always_comb begin
    stateNxt = state;
    case (state)
      DBG_OFF, DBG_PEND: begin
        if (!anyCause)          stateNxt = DBG_OFF;
        else if (instrBoundary) stateNxt = DBG_ON;
        else                    stateNxt = DBG_PEND;
      end
      DBG_ON:  if (!anyCause) stateNxt = DBG_OFF;
      default: stateNxt = DBG_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= DBG_OFF;
    else       state <= stateNxt;
  end

  assign probeAck       = (state == DBG_ON);
  assign stallFetch     = probeAck;
  assign intMask        = probeAck;
  assign resetViolation = resetReq & probeAck;

  // R4
  ack_on_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(probeAck) |-> $past(instrBoundary));

  // R7
  ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(probeAck) |-> $past(!pinCause && !tapCause));

  // R10
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (probeAck && anyCause) |=> probeAck);

  // R6
  tap_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tapCause) |-> $past(strb.clrTap));

  // R5
  pin_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pinCause) |-> $past(strb.clrPin));

endmodule

// File: rtl/debug_halt_ctrl.sv
module debug_halt_ctrl
  import dhc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic runStopN,
  input  logic tapDbgSel,
  input  logic tapIrClear,
  input  logic tapReset,
  input  logic instrBoundary,
  input  logic resetReq,
  output logic probeAck,
  output logic stallFetch,
  output logic intMask,
  output logic resetViolation
);

  causeStrb_t strb;

  dhc_control #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .runStopN   (runStopN),
    .tapDbgSel  (tapDbgSel),
    .tapIrClear (tapIrClear),
    .tapReset   (tapReset),
    .strb       (strb)
  );

  dhc_datapath dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .instrBoundary  (instrBoundary),
    .resetReq       (resetReq),
    .probeAck       (probeAck),
    .stallFetch     (stallFetch),
    .intMask        (intMask),
    .resetViolation (resetViolation)
  );

endmodule

// File: tb/debug_halt_ctrl_tb_top.sv
module debug_halt_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 36;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runStopN = 1'b1;
  logic tapDbgSel = 1'b0;
  logic tapIrClear = 1'b0;
  logic tapReset = 1'b0;
  logic instrBoundary = 1'b0;
  logic resetReq = 1'b0;
  logic probeAck, stallFetch, intMask, resetViolation;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  debug_halt_ctrl dut_i (
    .clk(clk), .rstN(rstN), .runStopN(runStopN), .tapDbgSel(tapDbgSel),
    .tapIrClear(tapIrClear), .tapReset(tapReset), .instrBoundary(instrBoundary),
    .resetReq(resetReq), .probeAck(probeAck), .stallFetch(stallFetch),
    .intMask(intMask), .resetViolation(resetViolation)
  );

  // Vector: {runStopN, tapDbgSel, tapIrClear, tapReset, instrBoundary, resetReq,
  //          expAck, expViol, reqId}; one row per clock, checked after that edge
  localparam logic [11:0] VEC [NV] = '{
    12'b1000_10_00_0010, // R2 idle
    12'b0000_10_00_0010, // R2 pin falls
    12'b0000_10_00_0010,
    12'b0000_10_00_0010,
    12'b0000_10_10_0010, // R2 fourth edge
    12'b0000_11_11_1001, // R9 reset request in session
    12'b1000_10_10_0101, // R5 pin rises
    12'b1000_10_10_0101,
    12'b1000_10_10_0101,
    12'b1000_10_00_0101, // R5 fourth edge
    12'b1000_11_00_1001, // R9 no session, no flag
    12'b1100_00_00_0100, // R4 port request, no boundary
    12'b1100_00_00_0100,
    12'b1100_00_00_0100,
    12'b1100_10_10_0011, // R3 boundary arrives
    12'b1100_00_10_1010, // R10 hold without boundary
    12'b1010_00_10_0110, // R6 clear pulse
    12'b1000_00_00_0110,
    12'b0100_10_00_0011, // R3 both requests
    12'b0100_10_10_0011,
    12'b0100_10_10_0111, // R7
    12'b1100_10_10_0111,
    12'b1100_10_10_0111,
    12'b1100_10_10_0111,
    12'b1100_10_10_0111, // R7 port still holds
    12'b1001_10_10_0110, // R6 port reset
    12'b1000_10_00_0110,
    12'b0100_10_00_0011, // R3 both again
    12'b0100_10_10_0011,
    12'b0010_10_10_0111, // R7 port released first
    12'b0000_10_10_0111,
    12'b0000_10_10_0111,
    12'b1000_10_10_0111,
    12'b1000_10_10_0111,
    12'b1000_10_10_0111,
    12'b1000_10_00_0101  // R5 pin release ends session
  };

  function automatic string reqName(input logic [3:0] id);
    case (id)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd9:    return "R9";
      4'd10:   return "R10";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chkOuts(input logic expAck, input string req);
    chk(probeAck, expAck, req, "probeAck");
    chk(stallFetch, expAck, "R8", "stallFetch");
    chk(intMask, expAck, "R8", "intMask");
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    chkOuts(1'b0, "R1");
    @(negedge clk);
    rstN = 1'b1;
    step();
    chkOuts(1'b0, "R1");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      runStopN      = VEC[i][11];
      tapDbgSel     = VEC[i][10];
      tapIrClear    = VEC[i][9];
      tapReset      = VEC[i][8];
      instrBoundary = VEC[i][7];
      resetReq      = VEC[i][6];
      step();
      chkOuts(VEC[i][5], reqName(VEC[i][3:0]));
      chk(resetViolation, VEC[i][4], "R9", "resetViolation");
    end

    // R4 pin request pending while boundary stays low
    @(negedge clk);
    runStopN = 1'b0; tapIrClear = 1'b0; tapReset = 1'b0;
    instrBoundary = 1'b0; resetReq = 1'b0; tapDbgSel = 1'b0;
    for (int k = 0; k < 8; k++) begin
      step();
      chkOuts(1'b0, "R4");
    end
    @(negedge clk);
    instrBoundary = 1'b1;
    step();
    chkOuts(1'b1, "R4");

    // R5 pin rise with boundary low: four edges to drop
    @(negedge clk);
    instrBoundary = 1'b0;
    runStopN = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      chkOuts(1'b1, "R5");
    end
    step();
    chkOuts(1'b0, "R5");

    // R1 system reset in mid-session clears flags
    @(negedge clk);
    tapDbgSel = 1'b1;
    instrBoundary = 1'b1;
    step();
    step();
    chkOuts(1'b1, "R3");
    @(negedge clk);
    rstN = 1'b0;
    tapDbgSel = 1'b0;
    #1;
    chkOuts(1'b0, "R1");
    @(negedge clk);
    rstN = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      chkOuts(1'b0, "R1");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule